// File: doc/BRIEF.md
# Edge-Interrupt General-Purpose I/O Port

This block is an eight-pin general-purpose I/O port that sits on a small synchronous register bus. Software uses it to drive an output latch, to pick which pins the port drives, and to watch input pins for transitions. Each input pin passes through a two-stage synchronizer. A transition of the selected direction, chosen per pin, sets a sticky flag bit. Software clears a flag by writing a one to it. One interrupt request line is high while any flag is set on a pin whose interrupt enable bit is set.

A serial peripheral beside the port can take over chosen pins. While its enable input is high, the pins named in its ownership mask take their output value and output enable from the peripheral and not from the port registers. Reads of the data register take the latch for output pins and the synchronized pin level for input pins, so software sees the real pin state in either direction.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, every register reads 0, `irq` is low, and `pin_oe` is 0.
- R2: The register addresses are 0 for output data, 1 for direction, 2 for interrupt enable, 3 for edge polarity and 4 for flags. The data, direction, enable and polarity registers read back the value last written. Addresses 5 to 7 read 0, and writes to them change no register.
- R3: A read of address 0 returns, for each bit, the data latch where the direction bit is 1 and the synchronized pin level where the direction bit is 0. The pin level is visible two clock edges after the pin changes.
- R4: With the peripheral disabled, `pin_out` equals the data latch and `pin_oe` equals the direction register.
- R5: Polarity bit 0 selects falling edges and 1 selects rising edges. An edge of the selected direction sets the matching flag on the third rising clock edge after the pin changes. An edge of the other direction leaves the flag unchanged, and several pins can set their flags in the same cycle.
- R6: Writing 1 to a flag bit at address 4 clears it. Writing 0 leaves that bit unchanged.
- R7: When an active edge and a write-one-to-clear reach the same flag bit in the same cycle, the flag ends up set.
- R8: `irq` is high exactly when some bit has both its flag and its enable set. A set flag whose enable bit is 0 does not raise `irq`.
- R9: While `per_en` is 1, each pin whose `per_mask` bit is 1 takes `pin_out` from `per_out` and `pin_oe` from `per_oe`. All other pins keep the port values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address, 0 when not selected |
| pin_in | input | 8 | Raw pin levels from the pads |
| pin_out | output | 8 | Output levels to the pads |
| pin_oe | output | 8 | Output enables to the pads |
| per_en | input | 1 | Serial peripheral enabled |
| per_mask | input | 8 | Pins owned by the peripheral |
| per_out | input | 8 | Peripheral output levels |
| per_oe | input | 8 | Peripheral output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
A stuck or wrongly cleared flag shows on `irq` in the same cycle as the register update, as long as that bit's enable is set. With the enable clear, it shows at the next read of address 4. A synchronizer or compare stage that is off by one moves the flag update by one cycle. The bench catches this by reading the flags on the third edge after a pin change and by timing a clear write to land on the same edge as the detected event. A wrong direction, latch or override bit shows at once on `pin_out` and `pin_oe`, and a wrong read mux shows on the next read of address 0.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIR  = 3'd1;
  localparam logic [ADDR_W-1:0] A_IEN  = 3'd2;
  localparam logic [ADDR_W-1:0] A_POL  = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAG = 3'd4;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;
  logic [WIDTH-1:0]             prev_q;

  always_comb begin
    stg_d[0] = pin_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_comb begin
      stg_d[s] = stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      prev_q <= '0;
    end else begin
      stg_q  <= stg_d;
      prev_q <= stg_q[LAST];
    end
  end

  always_comb begin
    lvl_o  = stg_q[LAST];
    rise_o = stg_q[LAST] & ~prev_q;
    fall_o = ~stg_q[LAST] & prev_q;
  end

  // R5
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o & $past(rise_o)) == '0);
  // R5
  rise_fall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o & fall_o) == '0);
endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rise_i,
  input  logic [WIDTH-1:0] fall_i,
  input  logic [WIDTH-1:0] pol_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] flag_o
);
  logic [WIDTH-1:0] flag_q;
  logic [WIDTH-1:0] flag_d;
  logic [WIDTH-1:0] hit;

  // R5: polarity 1 = rising, 0 = falling
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_comb begin
      hit[b] = pol_i[b] ? rise_i[b] : fall_i[b];
    end
  end

  // R6, R7: clear first, then set, so a same-cycle event survives
  always_comb begin
    flag_d = (flag_q & ~clr_i) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R6
  flag_clear_only_by_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (~flag_q & $past(flag_q) & ~$past(clr_i)) == '0);
  // R5
  flag_set_only_by_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q & ~$past(flag_q) & ~$past(hit)) == '0);
  // R7
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit & clr_i) != '0) |=> ((flag_q & $past(hit & clr_i)) == $past(hit & clr_i)));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  lvl_i,
  input  logic [WIDTH-1:0]  flag_i,
  output logic [WIDTH-1:0]  data_o,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  ien_o,
  output logic [WIDTH-1:0]  pol_o,
  output logic [WIDTH-1:0]  clr_o
);
  logic [WIDTH-1:0] data_q, data_d;
  logic [WIDTH-1:0] dir_q,  dir_d;
  logic [WIDTH-1:0] ien_q,  ien_d;
  logic [WIDTH-1:0] pol_q,  pol_d;
  logic             wr_en;
  logic [WIDTH-1:0] data_view;

  assign wr_en = bus_sel & bus_wr;

  always_comb begin
    data_d = data_q;
    dir_d  = dir_q;
    ien_d  = ien_q;
    pol_d  = pol_q;
    clr_o  = '0;
    if (wr_en) begin
      unique case (bus_addr)
        A_DATA:  data_d = bus_wdata;
        A_DIR:   dir_d  = bus_wdata;
        A_IEN:   ien_d  = bus_wdata;
        A_POL:   pol_d  = bus_wdata;
        A_FLAG:  clr_o  = bus_wdata;
        default: ;
      endcase
    end
  end

  // R1: all registers clear on reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      ien_q  <= '0;
      pol_q  <= '0;
    end else begin
      data_q <= data_d;
      dir_q  <= dir_d;
      ien_q  <= ien_d;
      pol_q  <= pol_d;
    end
  end

  // R3: per-bit latch or pin level
  for (genvar b = 0; b < WIDTH; b++) begin : g_view
    always_comb begin
      data_view[b] = dir_q[b] ? data_q[b] : lvl_i[b];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (bus_addr)
        A_DATA:  bus_rdata = data_view;
        A_DIR:   bus_rdata = dir_q;
        A_IEN:   bus_rdata = ien_q;
        A_POL:   bus_rdata = pol_q;
        A_FLAG:  bus_rdata = flag_i;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign data_o = data_q;
  assign dir_o  = dir_q;
  assign ien_o  = ien_q;
  assign pol_o  = pol_q;

  // R2
  unmapped_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr > A_FLAG) |=>
      ($stable(data_q) && $stable(dir_q) && $stable(ien_q) && $stable(pol_q)));
  // R6
  clear_only_on_flag_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_o != '0) |-> (wr_en && bus_addr == A_FLAG));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic             per_en,
  input  logic [WIDTH-1:0] per_mask,
  input  logic [WIDTH-1:0] per_out,
  input  logic [WIDTH-1:0] per_oe,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  // R4, R9: peripheral takes priority on owned pins
  for (genvar b = 0; b < WIDTH; b++) begin : g_pin
    logic own;
    always_comb begin
      own        = per_en & per_mask[b];
      pin_out[b] = own ? per_out[b] : data_i[b];
      pin_oe[b]  = own ? per_oe[b]  : dir_i[b];
    end
  end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  input  logic              per_en,
  input  logic [WIDTH-1:0]  per_mask,
  input  logic [WIDTH-1:0]  per_out,
  input  logic [WIDTH-1:0]  per_oe,
  output logic              irq
);
  logic [WIDTH-1:0] lvl, rise, fall;
  logic [WIDTH-1:0] data, dir, ien, pol, clr, flag;

  gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_in),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  gpio_edge_flags #(.WIDTH(WIDTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .fall_i(fall),
    .pol_i(pol), .clr_i(clr), .flag_o(flag)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lvl_i(lvl), .flag_i(flag), .data_o(data), .dir_o(dir),
    .ien_o(ien), .pol_o(pol), .clr_o(clr)
  );

  gpio_pin_mux #(.WIDTH(WIDTH)) u_mux (
    .data_i(data), .dir_i(dir), .per_en(per_en), .per_mask(per_mask),
    .per_out(per_out), .per_oe(per_oe), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // R8
  assign irq = |(flag & ien);

  // R8
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (flag != $past(flag) || ien != $past(ien)));
  // R9
  unowned_pin_follows_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !per_en |-> (pin_oe == dir));
endmodule

// File: tb/tb_gpio_edge_port.sv
`timescale 1ns/1ps
module tb_gpio_edge_port;
  localparam int W = 8;

  typedef struct {
    int         kind;   // 0 rdata, 1 irq, 2 pin_out, 3 pin_oe
    logic [7:0] exp;
    string      req;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0, bus_rdata;
  logic [W-1:0] pin_in = '0, pin_out, pin_oe;
  logic         per_en = 1'b0;
  logic [W-1:0] per_mask = '0, per_out = '0, per_oe = '0;
  logic         irq;

  item_t sb_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_edge_port dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .per_en(per_en), .per_mask(per_mask), .per_out(per_out),
    .per_oe(per_oe), .irq(irq)
  );

  // monitor: compare everything queued since the last edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0: act = bus_rdata;
        1: act = {7'd0, irq};
        2: act = pin_out;
        default: act = pin_oe;
      endcase
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_item(input int kind, input logic [7:0] exp, input string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    expect_item(0, exp, req);
    tick(1);
    bus_sel = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    for (int a = 0; a < 5; a++) rd(a[2:0], 8'h00, "R1");
    expect_item(1, 8'h00, "R1"); expect_item(3, 8'h00, "R1");
    tick(1);
    // R2, R4 latch and direction
    wr(3'd0, 8'hA5); wr(3'd1, 8'hFF);
    expect_item(2, 8'hA5, "R4"); expect_item(3, 8'hFF, "R4");
    rd(3'd0, 8'hA5, "R3"); rd(3'd1, 8'hFF, "R2");
    wr(3'd2, 8'h3C); rd(3'd2, 8'h3C, "R2"); wr(3'd2, 8'h00);
    // R2 unmapped
    wr(3'd6, 8'hFF);
    rd(3'd6, 8'h00, "R2"); rd(3'd0, 8'hA5, "R2"); rd(3'd2, 8'h00, "R2");
    // R3 mixed read
    wr(3'd1, 8'h0F);
    pin_in = 8'h30;
    tick(3);
    rd(3'd0, 8'h35, "R3");
    rd(3'd4, 8'h00, "R5 rising ignored with falling polarity");
    // R5 several falling edges together
    pin_in = 8'h00;
    tick(3);
    rd(3'd4, 8'h30, "R5");
    expect_item(1, 8'h00, "R8 masked");
    // R8 enable
    wr(3'd2, 8'h10);
    expect_item(1, 8'h01, "R8");
    // R6 clear
    wr(3'd4, 8'h20); rd(3'd4, 8'h10, "R6"); expect_item(1, 8'h01, "R8");
    wr(3'd4, 8'h00); rd(3'd4, 8'h10, "R6 zero write");
    wr(3'd4, 8'h10); rd(3'd4, 8'h00, "R6"); expect_item(1, 8'h00, "R8");
    // R5 rising polarity, R7 collision
    wr(3'd3, 8'h04); rd(3'd3, 8'h04, "R2");
    pin_in = 8'h04;
    tick(2);
    wr(3'd4, 8'h04);
    rd(3'd4, 8'h04, "R7");
    expect_item(1, 8'h00, "R8 flag not enabled");
    wr(3'd4, 8'h04); rd(3'd4, 8'h00, "R6");
    // R9 override
    per_mask = 8'hC0; per_out = 8'h40; per_oe = 8'hC0; per_en = 1'b1;
    tick(1);
    expect_item(2, 8'h65, "R9"); expect_item(3, 8'hCF, "R9");
    tick(1);
    per_en = 1'b0;
    tick(1);
    expect_item(2, 8'hA5, "R9 off"); expect_item(3, 8'h0F, "R9 off");
    tick(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule